// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditional branch or a predicated operation goes ahead. It reads the four stored status flags (negative, zero, carry, overflow) and a 4-bit condition selector, and returns a single pass bit within the same cycle. It has no clock and no state. The pass bit is meant to gate a branch or an instruction's write-back in the pipeline stage that sees both the flags and the selector.

The selector covers several kinds of test. Equality tests read only the zero flag. Unsigned ordering tests use the carry flag together with zero. Signed ordering tests use only negative, overflow and zero, and never carry. Direct tests on the negative and overflow flags are included, and so is an unconditional pass.

Machines differ in how they store carry after a subtract. The parameter `BORROW_CARRY` sets that convention. When it is 0, a carry of 1 means "no borrow". When it is 1, a carry of 1 means "borrow", and every unsigned ordering test reads the opposite carry value. In both settings, a compare of A minus B followed by this evaluator orders A and B correctly whether the operands are read as signed or as unsigned.

Top module: `cond_gate`

## Requirements
- R1: Code 0 passes exactly when the zero flag is 1. Code 1 passes exactly when the zero flag is 0.
- R2: Code 4 passes when negative is 1 and code 5 when negative is 0. Code 6 passes when overflow is 1 and code 7 when overflow is 0.
- R3: Code 10 (signed greater or equal) passes when negative equals overflow, and code 11 (signed less) passes when they differ. The carry flag has no effect on either code.
- R4: Code 12 (signed greater) passes when zero is 0 and negative equals overflow. Code 13 (signed less or equal) is its complement. The carry flag has no effect on either code.
- R5: The effective no-borrow bit equals the carry flag when `BORROW_CARRY`=0 and the inverted carry flag when `BORROW_CARRY`=1. Code 2 (unsigned greater or equal) passes when this bit is 1, and code 3 (unsigned less) is its complement.
- R6: Code 8 (unsigned higher) passes when the no-borrow bit is 1 and zero is 0. Code 9 (unsigned lower or same) is its complement.
- R7: Codes 14 and 15 always pass, whatever the flags are.
- R8: After a 4-bit compare of A minus B, every code orders A and B correctly, in both carry conventions and for all 256 operand pairs. This includes pairs such as 0 against 8, which order one way when read as unsigned and the other way when read as signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_code | input | 4 | Condition selector, encoded as listed in R1 to R7 |
| flag_n | input | 1 | Stored negative flag |
| flag_z | input | 1 | Stored zero flag |
| flag_c | input | 1 | Stored carry flag, with polarity set by BORROW_CARRY |
| flag_v | input | 1 | Stored overflow flag |
| cond_pass | output | 1 | 1 when the selected condition holds |

## Verification
The block is combinational, so a wrong predicate or a wrong select path shows on `cond_pass` in the same evaluation as the bad input. Nothing is held over to a later cycle. The most likely faults are a wrong carry polarity, a signed test that reads carry, or a missing complement on an odd code. Each of these turns the pass bit the wrong way for a whole class of operand pairs, such as unsigned 0 against 8. An exhaustive compare sweep under both carry conventions therefore exposes it at once.

// File: rtl/cond_gate_pkg.sv
// Shared types for the condition code evaluator.
// Assumes a 4-bit selector. Each odd code below 14 is the complement of
// the even code just before it.
package cond_gate_pkg;

    localparam int CODE_W     = 4;
    localparam int PRED_COUNT = 8;
    localparam int PRED_IDX_W = $clog2(PRED_COUNT);

    // Condition selector values; each pair shares one base predicate
    typedef enum logic [CODE_W-1:0] {
        COND_ZERO    = 4'd0,
        COND_NONZERO = 4'd1,
        COND_UGE     = 4'd2,
        COND_ULT     = 4'd3,
        COND_NEG     = 4'd4,
        COND_POS     = 4'd5,
        COND_OVF     = 4'd6,
        COND_NOOVF   = 4'd7,
        COND_UGT     = 4'd8,
        COND_ULE     = 4'd9,
        COND_SGE     = 4'd10,
        COND_SLT     = 4'd11,
        COND_SGT     = 4'd12,
        COND_SLE     = 4'd13,
        COND_ALWAYS  = 4'd14,
        COND_ALWAYS2 = 4'd15
    } cond_code_e;

    // Base predicate slots, indexed by the upper three selector bits
    typedef enum logic [PRED_IDX_W-1:0] {
        PRED_ZERO = 3'd0,
        PRED_UGE  = 3'd1,
        PRED_NEG  = 3'd2,
        PRED_OVF  = 3'd3,
        PRED_UGT  = 3'd4,
        PRED_SGE  = 3'd5,
        PRED_SGT  = 3'd6,
        PRED_TRUE = 3'd7
    } pred_idx_e;

    // Stored status flags
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/cond_gate_preds.sv
// Base predicate generator.
// Produces the eight even-code predicates from the stored flags.
// BORROW_CARRY selects how the carry flag is read: 0 means carry=1 is
// "no borrow", 1 means carry=1 is "borrow". Signed predicates never read
// carry. Purely combinational.
module cond_gate_preds
    import cond_gate_pkg::*;
#(
    parameter bit BORROW_CARRY = 1'b0
) (
    input  flags_t                flags,
    output logic [PRED_COUNT-1:0] preds
);

    logic no_borrow;
    logic signs_agree;

    // Pick the carry polarity once, at elaboration
    generate
        if (BORROW_CARRY) begin : g_borrow_carry
            assign no_borrow = ~flags.c;
        end else begin : g_plain_carry
            assign no_borrow = flags.c;
        end
    endgenerate

    // Build the base predicate vector
    always_comb begin
        signs_agree     = (flags.n == flags.v);
        preds           = '0;
        preds[PRED_ZERO] = flags.z;
        preds[PRED_UGE]  = no_borrow;
        preds[PRED_NEG]  = flags.n;
        preds[PRED_OVF]  = flags.v;
        preds[PRED_UGT]  = no_borrow & ~flags.z;
        preds[PRED_SGE]  = signs_agree;
        preds[PRED_SGT]  = signs_agree & ~flags.z;
        preds[PRED_TRUE] = 1'b1;
    end

    // Strict orderings must imply the non-strict ones
    always_comb begin
        if (!$isunknown(flags)) begin
            p_ugt_within_uge_r6: assert (!preds[PRED_UGT] || preds[PRED_UGE])
                else $error("unsigned higher without higher-or-same");
            p_sgt_within_sge_r4: assert (!preds[PRED_SGT] || preds[PRED_SGE])
                else $error("signed greater without greater-or-equal");
        end
    end

endmodule

// File: rtl/cond_gate_pick.sv
// Condition selector.
// Uses the upper three selector bits to pick one base predicate. The
// lowest bit inverts the result, except in the last pair, where both
// codes pass unconditionally. Purely combinational.
module cond_gate_pick
    import cond_gate_pkg::*;
(
    input  logic [CODE_W-1:0]     code,
    input  logic [PRED_COUNT-1:0] preds,
    output logic                  pass
);

    localparam logic [PRED_IDX_W-1:0] LAST_SLOT = PRED_IDX_W'(PRED_COUNT - 1);

    logic [PRED_IDX_W-1:0] slot;
    logic                  invert;

    // Select the base predicate and apply the odd-code complement
    always_comb begin
        slot   = code[CODE_W-1:1];
        invert = code[0] & (slot != LAST_SLOT);
        pass   = preds[slot] ^ invert;
    end

    // The last pair must always pass
    always_comb begin
        if (!$isunknown({code, preds})) begin
            p_last_pair_passes_r7: assert (slot != LAST_SLOT || pass)
                else $error("always code did not pass");
        end
    end

endmodule

// File: rtl/cond_gate.sv
// Condition code evaluator, top level.
// Turns the stored N/Z/C/V flags and a 4-bit selector into one pass bit
// that gates a branch or a predicated operation. BORROW_CARRY gives the
// carry polarity after a subtract. No clock and no state.
module cond_gate
    import cond_gate_pkg::*;
#(
    parameter bit BORROW_CARRY = 1'b0
) (
    input  logic [3:0] cond_code,
    input  logic       flag_n,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic       flag_v,
    output logic       cond_pass
);

    flags_t                flags;
    logic [PRED_COUNT-1:0] preds;

    // Pack the flag pins into the shared struct
    always_comb begin
        flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
    end

    cond_gate_preds #(
        .BORROW_CARRY (BORROW_CARRY)
    ) i_preds (
        .flags (flags),
        .preds (preds)
    );

    cond_gate_pick i_pick (
        .code  (cond_code),
        .preds (preds),
        .pass  (cond_pass)
    );

    // Check port-level behaviour of the equality and signed paths
    always_comb begin
        if (!$isunknown({cond_code, flag_n, flag_z, flag_c, flag_v})) begin
            p_zero_code_tracks_z_r1: assert (cond_code != COND_ZERO || cond_pass == flag_z)
                else $error("zero code does not follow Z");
            p_nonzero_code_r1: assert (cond_code != COND_NONZERO || cond_pass == !flag_z)
                else $error("nonzero code does not follow Z");
            p_sge_from_n_v_r3: assert (cond_code != COND_SGE || cond_pass == (flag_n == flag_v))
                else $error("signed greater-or-equal wrong");
            p_slt_from_n_v_r3: assert (cond_code != COND_SLT || cond_pass == (flag_n != flag_v))
                else $error("signed less wrong");
        end
    end

endmodule

// File: tb/test_cond_gate.sv
// Bench for the condition code evaluator. Two instances cover the two
// carry conventions. It sweeps every 4-bit compare with every code, then
// drives seeded random flags and a few directed corner cases.
module test_cond_gate;

    logic       clk;
    logic       rst_n;
    logic [3:0] code;
    logic       fn, fz, fc, fv;
    logic       fc_b;
    logic       pass_nb;
    logic       pass_b;

    int checks;
    int errors;
    int cycles;

    // 125 MHz bench clock
    initial clk = 1'b0;
    always #4 clk = ~clk;

    cond_gate #(.BORROW_CARRY(1'b0)) i_cond_gate (
        .cond_code (code), .flag_n (fn), .flag_z (fz),
        .flag_c (fc), .flag_v (fv), .cond_pass (pass_nb)
    );

    cond_gate #(.BORROW_CARRY(1'b1)) i_cond_gate_borrow (
        .cond_code (code), .flag_n (fn), .flag_z (fz),
        .flag_c (fc_b), .flag_v (fv), .cond_pass (pass_b)
    );

    // Expected pass bit from flags; nb is the no-borrow bit (R1 to R7)
    function automatic logic exp_flags(input logic [3:0] c, input logic n,
                                       input logic z, input logic nb,
                                       input logic v);
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return nb;
            4'd3:  return !nb;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return nb && !z;
            4'd9:  return !(nb && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    // Requirement tag for each code
    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd1:   return "R1";
            4'd4, 4'd5, 4'd6, 4'd7: return "R2";
            4'd10, 4'd11: return "R3";
            4'd12, 4'd13: return "R4";
            4'd2, 4'd3:   return "R5";
            4'd8, 4'd9:   return "R6";
            default:      return "R7";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive flags on the falling edge and sample one ns later
    task automatic apply(input logic [3:0] c, input logic n, input logic z,
                         input logic nb, input logic v);
        @(negedge clk);
        code = c; fn = n; fz = z; fv = v;
        fc   = nb;
        fc_b = !nb;
        #1;
    endtask

    // Compare sweep: order A and B from integer arithmetic (R8)
    task automatic compare_sweep();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int sa, sb, sd;
                logic [3:0] diff;
                logic n, z, nb, v;
                sa = (a >= 8) ? a - 16 : a;
                sb = (b >= 8) ? b - 16 : b;
                sd = sa - sb;
                diff = 4'(a - b);
                n  = diff[3];
                z  = (diff == 4'd0);
                nb = (a >= b);
                v  = (sd > 7) || (sd < -8);
                for (int c = 0; c < 16; c++) begin
                    logic e;
                    case (c)
                        0:  e = (a == b);
                        1:  e = (a != b);
                        2:  e = (a >= b);
                        3:  e = (a < b);
                        4:  e = n;
                        5:  e = !n;
                        6:  e = v;
                        7:  e = !v;
                        8:  e = (a > b);
                        9:  e = (a <= b);
                        10: e = (sa >= sb);
                        11: e = (sa < sb);
                        12: e = (sa > sb);
                        13: e = (sa <= sb);
                        default: e = 1'b1;
                    endcase
                    apply(4'(c), n, z, nb, v);
                    check(pass_nb, e, "R8", $sformatf("nb a=%0d b=%0d code=%0d", a, b, c));
                    check(pass_b,  e, "R8", $sformatf("borrow a=%0d b=%0d code=%0d", a, b, c));
                end
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic keep;
        int   seed;
        checks = 0; errors = 0; cycles = 0;
        code = '0; fn = 0; fz = 0; fc = 0; fc_b = 1; fv = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Quiet start: code 0 with Z clear must not pass (R1)
        apply(4'd0, 0, 0, 0, 0);
        check(pass_nb, 1'b0, "R1", "initial code 0, Z=0");

        // Directed: unsigned 0 vs 8 is less, signed 0 vs -8 is greater (R8)
        apply(4'd3, 1, 0, 0, 1);
        check(pass_nb, 1'b1, "R8", "0 vs 8 unsigned less");
        check(pass_b,  1'b1, "R8", "0 vs 8 unsigned less, borrow");
        apply(4'd12, 1, 0, 0, 1);
        check(pass_nb, 1'b1, "R8", "0 vs -8 signed greater");

        // Directed: carry has no effect on signed codes (R3, R4)
        for (int c = 10; c < 14; c++) begin
            apply(4'(c), 1, 0, 0, 1);
            keep = pass_nb;
            apply(4'(c), 1, 0, 1, 1);
            check(pass_nb, keep, (c < 12) ? "R3" : "R4", "carry toggled on signed code");
        end

        // Directed: always codes with every flag combination (R7)
        for (int f = 0; f < 16; f++) begin
            apply(4'd14, f[3], f[2], f[1], f[0]);
            check(pass_nb, 1'b1, "R7", "code 14");
            apply(4'd15, f[3], f[2], f[1], f[0]);
            check(pass_b, 1'b1, "R7", "code 15");
        end

        // Directed: carry polarity on code 2 with raw C=1 (R5)
        @(negedge clk);
        code = 4'd2; fn = 0; fz = 0; fv = 0; fc = 1; fc_b = 1; #1;
        check(pass_nb, 1'b1, "R5", "raw C=1 no-borrow convention");
        check(pass_b,  1'b0, "R5", "raw C=1 borrow convention");

        // Directed: unsigned higher blocked by Z (R6)
        apply(4'd8, 0, 1, 1, 0);
        check(pass_nb, 1'b0, "R6", "higher with Z=1");
        check(pass_b,  1'b0, "R6", "higher with Z=1, borrow");

        compare_sweep();

        // Seeded random flags and codes
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] r;
            logic e;
            r = 8'($urandom);
            apply(r[7:4], r[3], r[2], r[1], r[0]);
            e = exp_flags(r[7:4], r[3], r[2], r[1], r[0]);
            check(pass_nb, e, req_of(r[7:4]), $sformatf("random code=%0d", r[7:4]));
            check(pass_b,  e, req_of(r[7:4]), $sformatf("random borrow code=%0d", r[7:4]));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule